// File: doc/BRIEF.md
# Mode-Banked Register File with Exception Entry

This block holds the sixteen architectural 32-bit registers of a processor core together with the shadow copies that belong to each privileged mode. It also holds the current status word and one saved status word for each exception mode. The mode field of the current status word chooses which physical copy an architectural index reaches. Changing banks therefore moves no data. The new mapping applies from the cycle after the status word changes.

The block arbitrates exception requests every cycle. Two level interrupt lines (fast and normal) are each gated by their mask bit. One synchronous request carries a 2-bit cause. When an exception is taken, the block does four things in one cycle: it saves the old status word into the target mode's saved slot, writes the return address into the target mode's r14, builds the new status byte and loads the vector into r15. The rest of the core reaches the block through two combinational read ports, one write port, a status-word write with field selects and a return strobe. A "user view" flag lets privileged code reach the user copies of the banked registers.

Top module: `banked_regfile`

## Requirements
- R1: Reset clears every register and every saved status word. The current status word becomes 0x000000D3, which is supervisor mode 0x13 in bits 4:0 with I (bit 7) and F (bit 6) set. r15 (`pc_o`) reads 0.
- R2: User (0x10) and system (0x1F) modes share one r13/r14. Supervisor (0x13), abort (0x17), undefined (0x1B) and IRQ (0x12) modes each have a private r13/r14. Outside FIQ mode, r0–r12 and r15 are shared by all modes.
- R3: FIQ mode (0x11) has private r8–r14. After FIQ mode is left, the shared r8–r12 are visible again, unchanged.
- R4: `exc_kind` and its targets are: 0 undefined → mode 0x1B, vector 0x04. 1 software interrupt → 0x13, 0x08. 2 prefetch abort → 0x17, 0x0C. 3 data abort → 0x17, 0x10. 4 IRQ → 0x12, 0x18. 5 FIQ → 0x11, 0x1C. A synchronous request uses `exc_code` as kinds 0–3.
- R5: On entry, the target's saved status takes the old status word and the target's r14 takes old r15 + 4. Bits 31:8 of the status word are kept. The low byte becomes {I=1, F, T(bit 5)=0, target mode}, and r15 takes the vector. A register write or status write presented in the same cycle is dropped.
- R6: FIQ entry sets F. Every other entry leaves F as it was.
- R7: The fast interrupt is taken only when F is clear and the normal interrupt only when I is clear. An unmasked FIQ beats an unmasked IRQ, and both beat a synchronous request. `exc_taken` is high in the cycle the entry happens.
- R8: A current-status write (`psr_sel_saved`=0) replaces bits 7:0 when `psr_fsel[0]` is set, but only in a privileged mode. It replaces bits 31:28 (N, Z, C, V) when `psr_fsel[1]` is set, in any mode.
- R9: A saved-status write (`psr_sel_saved`=1) is ignored in user and system mode, where `spsr_o` reads 0. In an exception mode, `psr_fsel[0]` replaces bits 7:0 and `psr_fsel[1]` replaces bits 31:24.
- R10: With `user_view` high, r13/r14 from an exception mode reach the user copies. From FIQ mode, r8–r14 reach the user copies. The flag applies to both read ports and the write port.
- R11: `ret_en` in an exception mode copies that mode's saved status into the current status word in one cycle. The new bank is visible from the next cycle. `ret_en` wins over a status write in the same cycle and is ignored in user and system mode.
- R12: A mode value outside the seven listed ones behaves as user mode. It uses the user bank, is unprivileged and has no saved status.
- R13: Read ports are combinational. A write takes effect at the next clock edge, and a write to index 15 changes `pc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data |
| user_view | input | 1 | Reach user copies of banked registers |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| psr_we | input | 1 | Status-word write enable |
| psr_sel_saved | input | 1 | 0 current status, 1 saved status of current mode |
| psr_fsel | input | 2 | Field selects: bit 0 control byte, bit 1 flags |
| psr_wdata | input | 32 | Status write data |
| ret_en | input | 1 | Restore status from saved copy |
| exc_valid | input | 1 | Synchronous exception request |
| exc_code | input | 2 | Synchronous exception cause |
| irq_req | input | 1 | Normal interrupt line |
| fiq_req | input | 1 | Fast interrupt line |
| exc_taken | output | 1 | Entry happens this cycle |
| exc_kind | output | 3 | Kind of the entry being taken |
| cpsr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status of current mode (0 if none) |
| pc_o | output | 32 | Current r15 |

## Verification
The bench goes after the bank boundaries. It writes r13 and r8 in one mode and reads them back from the modes that share or shadow them. A wrong mapping shows up as a leaked or lost value, and one copy of r8 for every mode would show the FIQ value after FIQ mode is left. It drives all three request kinds in one cycle with different mask states, so a swapped priority or an ignored mask enters the wrong vector. It also tries to write the control byte from user mode and from an unknown mode, and tries a saved-status write from system mode. A design that honoured any of these would change the mode or a saved word that the bench later reads back. Exception entry is also issued together with a register write, and a design that let the write through would corrupt that register.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  typedef enum logic [2:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2,
    BK_SVC = 3'd3, BK_ABT = 3'd4, BK_UND = 3'd5
  } bank_e;

  typedef enum logic [2:0] {
    EK_UND = 3'd0, EK_SWI = 3'd1, EK_PABT = 3'd2,
    EK_DABT = 3'd3, EK_IRQ = 3'd4, EK_FIQ = 3'd5
  } exc_kind_e;

  localparam logic [4:0] MD_USR = 5'h10;
  localparam logic [4:0] MD_FIQ = 5'h11;
  localparam logic [4:0] MD_IRQ = 5'h12;
  localparam logic [4:0] MD_SVC = 5'h13;
  localparam logic [4:0] MD_ABT = 5'h17;
  localparam logic [4:0] MD_UND = 5'h1B;
  localparam logic [4:0] MD_SYS = 5'h1F;

  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  // 16 shared + 7 fast-interrupt + 4 x 2 exception-mode copies
  localparam int NPHYS  = 31;
  localparam int NSAVED = 5;

  function automatic bank_e bank_of(input logic [4:0] mode);
    case (mode)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;
    endcase
  endfunction
endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
  import bankreg_pkg::*;
(
  input  bank_e      bank,
  input  logic       user_view,
  input  logic [3:0] idx,
  output logic [4:0] phys
);
  logic [3:0] lo;
  logic [4:0] base;

  always_comb begin
    lo   = 4'd13;
    base = 5'd0;
    case (bank)
      BK_FIQ: begin lo = 4'd8; base = 5'd16; end
      BK_IRQ: base = 5'd23;
      BK_SVC: base = 5'd25;
      BK_ABT: base = 5'd27;
      BK_UND: base = 5'd29;
      default: base = 5'd0;
    endcase
    if (!user_view && bank != BK_USR && idx >= lo && idx <= 4'd14)
      phys = base + {1'b0, idx - lo};
    else
      phys = {1'b0, idx};
  end
endmodule

// File: rtl/bankreg_vector.sv
module bankreg_vector
  import bankreg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  exc_kind_e        kind,
  output logic [4:0]       tgt_mode,
  output logic [XLEN-1:0]  vector,
  output logic             is_fiq
);
  always_comb begin
    is_fiq = 1'b0;
    case (kind)
      EK_UND:  begin tgt_mode = MD_UND; vector = XLEN'(8'h04); end
      EK_SWI:  begin tgt_mode = MD_SVC; vector = XLEN'(8'h08); end
      EK_PABT: begin tgt_mode = MD_ABT; vector = XLEN'(8'h0C); end
      EK_DABT: begin tgt_mode = MD_ABT; vector = XLEN'(8'h10); end
      EK_IRQ:  begin tgt_mode = MD_IRQ; vector = XLEN'(8'h18); end
      EK_FIQ:  begin tgt_mode = MD_FIQ; vector = XLEN'(8'h1C); is_fiq = 1'b1; end
      default: begin tgt_mode = MD_SVC; vector = '0; end
    endcase
  end
endmodule

// File: rtl/bankreg_psr.sv
module bankreg_psr
  import bankreg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [4:0]      tgt_mode,
  input  logic            is_fiq,
  input  logic            ret_en,
  input  logic            psr_we,
  input  logic            sel_saved,
  input  logic [1:0]      fsel,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] cpsr,
  output logic [XLEN-1:0] spsr_cur,
  output bank_e           cur_bank
);
  logic [XLEN-1:0] cpsr_q;
  logic [XLEN-1:0] spsr_q [NSAVED];
  logic [2:0] cur_slot, tgt_slot;
  logic has_saved, priv;
  bank_e tgt_bank;

  assign cur_bank  = bank_of(cpsr_q[4:0]);
  assign tgt_bank  = bank_of(tgt_mode);
  assign cur_slot  = 3'(cur_bank) - 3'd1;
  assign tgt_slot  = 3'(tgt_bank) - 3'd1;
  assign has_saved = (cur_bank != BK_USR);
  assign priv      = has_saved || (cpsr_q[4:0] == MD_SYS);
  assign cpsr      = cpsr_q;
  assign spsr_cur  = has_saved ? spsr_q[cur_slot] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpsr_q <= XLEN'({1'b1, 1'b1, 1'b0, MD_SVC});
      for (int s = 0; s < NSAVED; s++) spsr_q[s] <= '0;
    end else if (take) begin
      spsr_q[tgt_slot] <= cpsr_q;
      cpsr_q[7:0] <= {1'b1, is_fiq | cpsr_q[BIT_F], 1'b0, tgt_mode};
    end else if (ret_en && has_saved) begin
      cpsr_q <= spsr_q[cur_slot];
    end else if (psr_we) begin
      if (!sel_saved) begin
        if (fsel[0] && priv) cpsr_q[7:0] <= wdata[7:0];
        if (fsel[1]) cpsr_q[XLEN-1 -: 4] <= wdata[XLEN-1 -: 4];
      end else if (has_saved) begin
        if (fsel[0]) spsr_q[cur_slot][7:0] <= wdata[7:0];
        if (fsel[1]) spsr_q[cur_slot][XLEN-1 -: 8] <= wdata[XLEN-1 -: 8];
      end
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            user_view,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            psr_we,
  input  logic            psr_sel_saved,
  input  logic [1:0]      psr_fsel,
  input  logic [XLEN-1:0] psr_wdata,
  input  logic            ret_en,
  input  logic            exc_valid,
  input  logic [1:0]      exc_code,
  input  logic            irq_req,
  input  logic            fiq_req,
  output logic            exc_taken,
  output logic [2:0]      exc_kind,
  output logic [XLEN-1:0] cpsr_o,
  output logic [XLEN-1:0] spsr_o,
  output logic [XLEN-1:0] pc_o
);
  localparam int NPORT = 4;  // read A, read B, write, link target
  localparam int PC_IX = 15;
  localparam int LR_IX = 14;

  logic [XLEN-1:0] gpr_q [NPHYS];
  logic fiq_go, irq_go;
  exc_kind_e kind;
  logic [4:0] tgt_mode;
  logic [XLEN-1:0] vector;
  logic is_fiq;
  bank_e cur_bank;

  assign fiq_go    = fiq_req && !cpsr_o[BIT_F];
  assign irq_go    = irq_req && !cpsr_o[BIT_I];
  assign exc_taken = fiq_go || irq_go || exc_valid;
  assign kind      = fiq_go ? EK_FIQ : irq_go ? EK_IRQ : exc_kind_e'({1'b0, exc_code});
  assign exc_kind  = kind;

  bankreg_vector #(.XLEN(XLEN)) u_vec (
    .kind(kind), .tgt_mode(tgt_mode), .vector(vector), .is_fiq(is_fiq)
  );

  bankreg_psr #(.XLEN(XLEN)) u_psr (
    .clk(clk), .rst_n(rst_n), .take(exc_taken), .tgt_mode(tgt_mode),
    .is_fiq(is_fiq), .ret_en(ret_en), .psr_we(psr_we),
    .sel_saved(psr_sel_saved), .fsel(psr_fsel), .wdata(psr_wdata),
    .cpsr(cpsr_o), .spsr_cur(spsr_o), .cur_bank(cur_bank)
  );

  logic [3:0] m_idx  [NPORT];
  logic       m_uv   [NPORT];
  bank_e      m_bank [NPORT];
  logic [4:0] m_phys [NPORT];

  assign m_idx[0] = rd_a_idx;  assign m_uv[0] = user_view; assign m_bank[0] = cur_bank;
  assign m_idx[1] = rd_b_idx;  assign m_uv[1] = user_view; assign m_bank[1] = cur_bank;
  assign m_idx[2] = wr_idx;    assign m_uv[2] = user_view; assign m_bank[2] = cur_bank;
  assign m_idx[3] = 4'(LR_IX); assign m_uv[3] = 1'b0;      assign m_bank[3] = bank_of(tgt_mode);

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    bankreg_map u_map (
      .bank(m_bank[p]), .user_view(m_uv[p]), .idx(m_idx[p]), .phys(m_phys[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NPHYS; r++) gpr_q[r] <= '0;
    end else if (exc_taken) begin
      gpr_q[m_phys[3]] <= gpr_q[PC_IX] + XLEN'(4);
      gpr_q[PC_IX]     <= vector;
    end else if (wr_en) begin
      gpr_q[m_phys[2]] <= wr_data;
    end
  end

  assign rd_a_data = gpr_q[m_phys[0]];
  assign rd_b_data = gpr_q[m_phys[1]];
  assign pc_o      = gpr_q[PC_IX];
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_valid,
  input logic            irq_req,
  input logic            fiq_req,
  input logic            ret_en,
  input logic            exc_taken,
  input logic [2:0]      exc_kind,
  input logic [XLEN-1:0] cpsr_o,
  input logic [XLEN-1:0] spsr_o,
  input logic [XLEN-1:0] pc_o
);
  function automatic logic [7:0] want_vec(input logic [2:0] k);
    case (k)
      3'd0: return 8'h04; 3'd1: return 8'h08; 3'd2: return 8'h0C;
      3'd3: return 8'h10; 3'd4: return 8'h18; default: return 8'h1C;
    endcase
  endfunction

  function automatic logic [4:0] want_mode(input logic [2:0] k);
    case (k)
      3'd0: return 5'h1B; 3'd1: return 5'h13; 3'd2: return 5'h17;
      3'd3: return 5'h17; 3'd4: return 5'h12; default: return 5'h11;
    endcase
  endfunction

  function automatic logic saved_mode(input logic [4:0] m);
    return m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B;
  endfunction

  // R7: unmasked fast interrupt always wins
  p_fiq_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_req && !cpsr_o[6]) |-> (exc_taken && exc_kind == 3'd5));

  // R7: nothing taken when every source is absent or masked
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && (!fiq_req || cpsr_o[6]) && (!irq_req || cpsr_o[7])) |-> !exc_taken);

  // R4: vector loaded into r15
  p_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> pc_o == XLEN'(want_vec($past(exc_kind))));

  // R4, R5: target mode with I set
  p_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> (cpsr_o[4:0] == want_mode($past(exc_kind)) && cpsr_o[7]));

  // R5: old status saved, upper bits kept
  p_saved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> (spsr_o == $past(cpsr_o) && cpsr_o[XLEN-1:8] == $past(cpsr_o[XLEN-1:8])));

  // R6: F untouched by non-fast entries, set by fast entry
  p_fmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && exc_kind != 3'd5) |=> cpsr_o[6] == $past(cpsr_o[6]));
  p_fset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && exc_kind == 3'd5) |=> cpsr_o[6]);

  // R11: return restores the saved word
  p_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !exc_taken && saved_mode(cpsr_o[4:0])) |=> cpsr_o == $past(spsr_o));
endmodule

bind banked_regfile banked_regfile_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .irq_req(irq_req),
  .fiq_req(fiq_req), .ret_en(ret_en), .exc_taken(exc_taken),
  .exc_kind(exc_kind), .cpsr_o(cpsr_o), .spsr_o(spsr_o), .pc_o(pc_o)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, psr_wdata;
  logic user_view, wr_en, psr_we, psr_sel_saved, ret_en;
  logic exc_valid, irq_req, fiq_req, exc_taken;
  logic [1:0] psr_fsel, exc_code;
  logic [2:0] exc_kind;
  logic [31:0] cpsr_o, spsr_o, pc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  banked_regfile dut (.*);

  // {source kind, expected mode, expected vector}
  localparam logic [15:0] ROWS [6] = '{
    {3'd0, 5'h1B, 8'h04}, {3'd1, 5'h13, 8'h08}, {3'd2, 5'h17, 8'h0C},
    {3'd3, 5'h17, 8'h10}, {3'd4, 5'h12, 8'h18}, {3'd5, 5'h11, 8'h1C}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; psr_we = 0; ret_en = 0; exc_valid = 0; irq_req = 0; fiq_req = 0;
    user_view = 0; psr_sel_saved = 0; psr_fsel = 0; exc_code = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic wreg(input logic [3:0] i, input logic [31:0] d, input logic uv);
    wr_en = 1; wr_idx = i; wr_data = d; user_view = uv; step();
  endtask

  task automatic rreg(input string req, input logic [3:0] i, input logic uv, input logic [31:0] exp);
    rd_a_idx = i; user_view = uv; #1;
    check(req, rd_a_data, exp);
    user_view = 0;
  endtask

  task automatic wpsr(input logic saved, input logic [1:0] f, input logic [31:0] d);
    psr_we = 1; psr_sel_saved = saved; psr_fsel = f; psr_wdata = d; step();
  endtask

  task automatic sync_exc(input logic [1:0] c);
    exc_valid = 1; exc_code = c; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(); rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0; psr_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    check("R1 cpsr", cpsr_o, 32'h0000_00D3);
    check("R1 pc", pc_o, 32'h0);
    rreg("R1 r13", 4'd13, 0, 32'h0);
    check("R1 spsr", spsr_o, 32'h0);

    // table: every exception kind from supervisor with masks clear (R4, R5, R6)
    for (int i = 0; i < 6; i++) begin
      logic [2:0] src; logic [4:0] md; logic [7:0] vec; logic [31:0] pcv;
      {src, md, vec} = ROWS[i];
      pcv = 32'h100 + 32'(i) * 32'h10;
      wpsr(0, 2'b01, 32'h13);
      wreg(4'd15, pcv, 0);
      if (src == 3'd4) irq_req = 1;
      else if (src == 3'd5) fiq_req = 1;
      else begin exc_valid = 1; exc_code = src[1:0]; end
      #1;
      check("R4 kind", {29'd0, exc_kind}, {29'd0, src});
      check("R7 taken", {31'd0, exc_taken}, 32'd1);
      step();
      check("R4 mode", {27'd0, cpsr_o[4:0]}, {27'd0, md});
      check("R4 vector", pc_o, {24'd0, vec});
      rreg("R5 link", 4'd14, 0, pcv + 32'd4);
      check("R5 saved", spsr_o, 32'h13);
      check("R6 fmask", {31'd0, cpsr_o[6]}, {31'd0, src == 3'd5});
    end

    // R7 masks: in FIQ with I and F set
    irq_req = 1; fiq_req = 1; #1;
    check("R7 masked", {31'd0, exc_taken}, 32'd0);
    idle();

    wpsr(0, 2'b01, 32'h13);
    // R5 write dropped on entry cycle
    wr_en = 1; wr_idx = 4'd3; wr_data = 32'h33; exc_valid = 1; exc_code = 2'd1; step();
    rreg("R5 drop", 4'd3, 0, 32'h0);
    check("R5 pc", pc_o, 32'h8);

    // R2, R8
    wreg(4'd13, 32'hAAAA_0013, 0);
    wpsr(0, 2'b01, 32'h10);
    check("R8 to user", {27'd0, cpsr_o[4:0]}, 32'h10);
    rreg("R2 user r13", 4'd13, 0, 32'h0);
    wreg(4'd13, 32'hBBBB_0010, 0);
    wpsr(0, 2'b01, 32'h13);
    check("R8 unpriv control", {27'd0, cpsr_o[4:0]}, 32'h10);
    wpsr(0, 2'b10, 32'hA000_0000);
    check("R8 flags", cpsr_o, 32'hA000_0010);

    sync_exc(2'd1);
    check("R5 status byte", cpsr_o, 32'hA000_0093);
    check("R5 saved user", spsr_o, 32'hA000_0010);
    rreg("R2 svc r13", 4'd13, 0, 32'hAAAA_0013);
    rreg("R10 user r13", 4'd13, 1, 32'hBBBB_0010);
    rreg("R5 link svc", 4'd14, 0, 32'hC);

    wpsr(0, 2'b01, 32'h1F);
    rreg("R2 sys r13", 4'd13, 0, 32'hBBBB_0010);
    wpsr(1, 2'b11, 32'hFFFF_FFFF);
    check("R9 sys spsr", spsr_o, 32'h0);
    wreg(4'd8, 32'hC8C8_C8C8, 0);

    // R3 FIQ bank
    wpsr(0, 2'b01, 32'h11);
    rreg("R3 fiq r8", 4'd8, 0, 32'h0);
    wreg(4'd8, 32'hF8F8_F8F8, 0);
    rreg("R10 fiq user r8", 4'd8, 1, 32'hC8C8_C8C8);
    rreg("R3 fiq r8 own", 4'd8, 0, 32'hF8F8_F8F8);
    wpsr(0, 2'b01, 32'h13);
    rreg("R3 shared r8", 4'd8, 0, 32'hC8C8_C8C8);
    check("R9 ignored write", spsr_o, 32'hA000_0010);
    wpsr(1, 2'b11, 32'h3000_0010);
    check("R9 svc write", spsr_o, 32'h3000_0010);

    // R11 return
    ret_en = 1; step();
    check("R11 restore", cpsr_o, 32'h3000_0010);
    rreg("R11 bank", 4'd13, 0, 32'hBBBB_0010);

    // R12 unknown mode
    sync_exc(2'd0);
    check("R4 und byte", cpsr_o, 32'h3000_009B);
    wpsr(0, 2'b01, 32'h15);
    check("R12 enter", {24'd0, cpsr_o[7:0]}, 32'h15);
    rreg("R12 user bank", 4'd13, 0, 32'hBBBB_0010);
    check("R12 no saved", spsr_o, 32'h0);
    wpsr(0, 2'b01, 32'h13);
    check("R12 unpriv", {27'd0, cpsr_o[4:0]}, 32'h15);

    // R7 priority
    sync_exc(2'd3);
    wpsr(0, 2'b01, 32'h13);
    fiq_req = 1; irq_req = 1; exc_valid = 1; exc_code = 2'd2; #1;
    check("R7 fiq first", {29'd0, exc_kind}, 32'd5);
    step();
    check("R7 fiq mode", {27'd0, cpsr_o[4:0]}, 32'h11);
    wpsr(0, 2'b01, 32'h51);
    fiq_req = 1; irq_req = 1; exc_valid = 1; exc_code = 2'd2; #1;
    check("R7 irq over sync", {29'd0, exc_kind}, 32'd4);
    step();
    check("R7 irq mode", {27'd0, cpsr_o[4:0]}, 32'h12);
    check("R6 F kept", {31'd0, cpsr_o[6]}, 32'd1);

    // R13 pc write, port B
    wreg(4'd15, 32'h1234, 0);
    check("R13 pc", pc_o, 32'h1234);
    rd_b_idx = 4'd15; #1;
    check("R13 port b", rd_b_data, 32'h1234);

    // R1 reset again
    rst_n = 0; step(); rst_n = 1; #1;
    check("R1 cpsr again", cpsr_o, 32'h0000_00D3);
    check("R1 pc again", pc_o, 32'h0);
    rreg("R1 r8 again", 4'd8, 0, 32'h0);
    check("R1 spsr again", spsr_o, 32'h0);

    finish_run();
  end
endmodule